// File: doc/BRIEF.md
# Countdown Event Timer with Interrupt

This block is a register-programmed down-counter that raises an interrupt once a programmed number of clock ticks has elapsed. It runs either once, stopping itself at expiry, or in auto-reload mode, where it restarts from a stored interval and fires at a fixed period. The interval is 56 bits wide. Because the register port is 32 bits wide, the interval is written in two parts. Software first writes the lower word. It then writes the control word, which holds the upper 24 interval bits next to the run, repeat and load bits, so that one write commits the whole value and starts the counter.

The interrupt path is split into a pending flag and an enable flag. An expiry sets the pending flag, and a write-one-to-clear register clears it. The enable flag has its own set register and its own clear register, so software never has to read, modify and write it back. The interrupt output is high only while both flags are set. Register reads are combinational from the address.

Top module: `evt_countdown_timer`

## Requirements
- R1: After reset the interrupt output is 0 and every register reads 0.
- R2: Offset 0x00 holds the lower 32 interval bits and reads them back. Offset 0x04 is the control word: bits [23:0] are the upper interval bits, bit 24 is run, bit 28 is repeat, and bit 30 is load. Load is a one-cycle strobe and always reads back as 0.
- R3: A control write with load=1 and run=1 puts {ctrl[23:0], low word} into the counter. For an interval N≥2, the pending flag is set at the Nth clock edge after the write edge and not before.
- R4: In one-shot mode (repeat=0) an expiry clears the run bit, so the control word reads back with bit 24 at 0, and no further expiry follows.
- R5: In repeat mode an expiry reloads the stored 56-bit interval and counting continues, so a new expiry comes every N edges.
- R6: A control write with load=0 updates run and repeat but keeps the count. The count does not step on the cycle of that write.
- R7: Writing zero to the control word stops the counter, and no expiry follows.
- R8: Writing 1 to bit 0 at offset 0x2C sets the interrupt enable. Writing 1 to bit 0 at offset 0x30 clears it. Bit 0 at 0x2C reads the enable, and offset 0x30 reads 0.
- R9: The interrupt output is high exactly when the pending flag and the enable are both set. Bit 0 at offset 0x34 reads the pending flag, and masking the interrupt does not lose a pending event.
- R10: Writing 1 to bit 0 at offset 0x34 clears the pending flag, and writing 0 there has no effect. If an expiry falls on the same edge as a clear, the flag stays set.
- R11: All 56 interval bits take part in the count. An interval with a nonzero upper field does not expire within a few hundred cycles even when its low word is small.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W (6) | Byte address of the register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for reg_addr, combinational |
| irq | output | 1 | Timer interrupt, high while pending and enabled |

## Verification
The properties assume that a write strobe lasts exactly one cycle and carries one address, so the enable-set and enable-clear strobes are never asserted together. They also assume the control word is written only after the low word it belongs to has been written. The stimulus drives every write through one task that raises the strobe for a single edge, and it always writes the low word before the control word. Random intervals are drawn between 2 and 24 ticks, the smallest legal interval and up, so that both expiry and auto-reload happen many times within a short run. Directed cases then place a clear exactly on a reload expiry and pause and resume an interval partway through.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   // Register byte offsets: software drivers decode these.
   localparam int OFS_LOW     = 'h00;
   localparam int OFS_CTL     = 'h04;
   localparam int OFS_IEN_SET = 'h2C;
   localparam int OFS_IEN_CLR = 'h30;
   localparam int OFS_PEND    = 'h34;

   // Control word field positions.
   localparam int HI_FIELD_W = 24;
   localparam int BIT_RUN    = 24;
   localparam int BIT_RPT    = 28;
   localparam int BIT_LOAD   = 30;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_LOW,
      SEL_CTL,
      SEL_IEN_SET,
      SEL_IEN_CLR,
      SEL_PEND
   } reg_sel_e;

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
   import evt_timer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 56,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              run_q,
   input  logic              rpt_q,
   input  logic              ien_q,
   input  logic              pend_q,
   output logic              ctl_wr,
   output logic              ctl_run_w,
   output logic              ctl_rpt_w,
   output logic              ctl_load_w,
   output logic              ien_set,
   output logic              ien_clr,
   output logic              pend_clr,
   output logic [CNT_W-1:0]  wr_value,
   output logic [CNT_W-1:0]  reload_q,
   output logic [DATA_W-1:0] rdata
);

   localparam int HI_W = CNT_W - DATA_W;

   if (HI_W < 1 || HI_W > HI_FIELD_W) begin : g_bad_cnt_w
      $error("CNT_W must exceed DATA_W by 1 to %0d bits", HI_FIELD_W);
   end
   if (DATA_W <= BIT_LOAD) begin : g_bad_data_w
      $error("DATA_W too narrow for the control fields");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register offsets");
   end

   reg_sel_e sel;

   always_comb begin
      sel = SEL_NONE;
      case (addr)
         ADDR_W'(OFS_LOW):     sel = SEL_LOW;
         ADDR_W'(OFS_CTL):     sel = SEL_CTL;
         ADDR_W'(OFS_IEN_SET): sel = SEL_IEN_SET;
         ADDR_W'(OFS_IEN_CLR): sel = SEL_IEN_CLR;
         ADDR_W'(OFS_PEND):    sel = SEL_PEND;
         default:              sel = SEL_NONE;
      endcase
   end

   logic [DATA_W-1:0] low_q;
   logic [HI_W-1:0]   hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
         hi_q  <= '0;
      end else if (wr) begin
         if (sel == SEL_LOW) low_q <= wdata;
         if (sel == SEL_CTL) hi_q  <= wdata[HI_W-1:0];
      end
   end

   assign ctl_wr     = wr && (sel == SEL_CTL);
   assign ctl_run_w  = wdata[BIT_RUN];
   assign ctl_rpt_w  = wdata[BIT_RPT];
   assign ctl_load_w = wdata[BIT_LOAD];
   assign ien_set    = wr && (sel == SEL_IEN_SET) && wdata[0];
   assign ien_clr    = wr && (sel == SEL_IEN_CLR) && wdata[0];
   assign pend_clr   = wr && (sel == SEL_PEND) && wdata[0];

   assign wr_value = {wdata[HI_W-1:0], low_q};
   assign reload_q = {hi_q, low_q};

   logic [HI_FIELD_W-1:0] hi_rd;
   if (HI_W == HI_FIELD_W) begin : g_hi_full
      assign hi_rd = hi_q;
   end else begin : g_hi_pad
      assign hi_rd = {{(HI_FIELD_W-HI_W){1'b0}}, hi_q};
   end

   logic [DATA_W-1:0] ctl_word;
   always_comb begin
      ctl_word                   = '0;
      ctl_word[HI_FIELD_W-1:0]   = hi_rd;
      ctl_word[BIT_RUN]          = run_q;
      ctl_word[BIT_RPT]          = rpt_q;
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_LOW:     rdata = low_q;
         SEL_CTL:     rdata = ctl_word;
         SEL_IEN_SET: rdata[0] = ien_q;
         SEL_PEND:    rdata[0] = pend_q;
         default:     rdata = '0;
      endcase
   end

endmodule

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
   parameter int CNT_W = 56
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             ctl_run_w,
   input  logic             ctl_rpt_w,
   input  logic             ctl_load_w,
   input  logic [CNT_W-1:0] wr_value,
   input  logic [CNT_W-1:0] reload_q,
   output logic [CNT_W-1:0] count_q,
   output logic             run_q,
   output logic             rpt_q,
   output logic             expire
);

   if (CNT_W < 2) begin : g_bad_w
      $error("CNT_W must be at least 2");
   end

   // Terminal when the next step would reach zero (count is 1 or 0).
   logic at_end;
   assign at_end = (count_q[CNT_W-1:1] == '0);
   assign expire = run_q && !ctl_wr && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         run_q   <= 1'b0;
         rpt_q   <= 1'b0;
      end else if (ctl_wr) begin
         run_q <= ctl_run_w;
         rpt_q <= ctl_rpt_w;
         if (ctl_load_w) count_q <= wr_value;
      end else if (run_q) begin
         if (at_end) begin
            if (rpt_q) begin
               count_q <= reload_q;
            end else begin
               count_q <= '0;
               run_q   <= 1'b0;
            end
         end else begin
            count_q <= count_q - CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic ien_set,
   input  logic ien_clr,
   input  logic pend_clr,
   input  logic expire,
   output logic ien_q,
   output logic pend_q,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (ien_set)      ien_q <= 1'b1;
         else if (ien_clr) ien_q <= 1'b0;
         // A fresh expiry outranks a clear on the same edge.
         if (expire)        pend_q <= 1'b1;
         else if (pend_clr) pend_q <= 1'b0;
      end
   end

   assign irq = pend_q & ien_q;

endmodule

// File: rtl/evt_countdown_timer.sv
module evt_countdown_timer #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 56,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);

   logic             ctl_wr, ctl_run_w, ctl_rpt_w, ctl_load_w;
   logic             ien_set, ien_clr, pend_clr;
   logic [CNT_W-1:0] wr_value, reload_q, count_q;
   logic             run_q, rpt_q, expire, ien_q, pend_q;

   evt_timer_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .run_q(run_q), .rpt_q(rpt_q), .ien_q(ien_q), .pend_q(pend_q),
      .ctl_wr(ctl_wr), .ctl_run_w(ctl_run_w), .ctl_rpt_w(ctl_rpt_w),
      .ctl_load_w(ctl_load_w), .ien_set(ien_set), .ien_clr(ien_clr),
      .pend_clr(pend_clr), .wr_value(wr_value), .reload_q(reload_q),
      .rdata(reg_rdata)
   );

   evt_timer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_run_w(ctl_run_w),
      .ctl_rpt_w(ctl_rpt_w), .ctl_load_w(ctl_load_w), .wr_value(wr_value),
      .reload_q(reload_q), .count_q(count_q), .run_q(run_q), .rpt_q(rpt_q),
      .expire(expire)
   );

   evt_timer_irq u_irq (
      .clk(clk), .rst_n(rst_n), .ien_set(ien_set), .ien_clr(ien_clr),
      .pend_clr(pend_clr), .expire(expire), .ien_q(ien_q), .pend_q(pend_q),
      .irq(irq)
   );

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
   parameter int CNT_W = 56
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic             ctl_run_w,
   input logic             ien_set,
   input logic             ien_clr,
   input logic             pend_clr,
   input logic             expire,
   input logic             run_q,
   input logic             rpt_q,
   input logic             ien_q,
   input logic             pend_q,
   input logic [CNT_W-1:0] count_q
);

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && !ctl_wr && (count_q > CNT_W'(1)) |=> count_q == $past(count_q) - CNT_W'(1));

   assert_oneshot_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire && !rpt_q |=> !run_q);

   assert_repeat_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      expire && rpt_q |=> run_q);

   assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |-> !expire);

   assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && !ctl_run_w |=> !run_q);

   assert_ien_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ien_set |=> ien_q);

   assert_ien_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ien_clr && !ien_set |=> !ien_q);

   assert_clr_drops_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_clr && !expire |=> !pend_q);

   assert_expiry_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> pend_q);

endmodule

bind evt_countdown_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_run_w(ctl_run_w),
   .ien_set(ien_set), .ien_clr(ien_clr), .pend_clr(pend_clr), .expire(expire),
   .run_q(run_q), .rpt_q(rpt_q), .ien_q(ien_q), .pend_q(pend_q), .count_q(count_q)
);

// File: tb/evt_countdown_timer_tb.sv
`timescale 1ns/1ps
module evt_countdown_timer_tb;

   localparam logic [5:0] A_LOW = 6'h00;
   localparam logic [5:0] A_CTL = 6'h04;
   localparam logic [5:0] A_IS  = 6'h2C;
   localparam logic [5:0] A_IC  = 6'h30;
   localparam logic [5:0] A_PD  = 6'h34;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   evt_countdown_timer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   function automatic logic [31:0] ctl(input logic [23:0] hi, input logic run,
                                       input logic rpt, input logic load);
      logic [31:0] w;
      w = {8'h00, hi};
      w[24] = run;
      w[28] = rpt;
      w[30] = load;
      return w;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Ends just after the committing control-write edge (edge 0).
   task automatic arm(input int n, input logic rpt);
      wr_reg(A_LOW, 32'(n));
      wr_reg(A_CTL, ctl(24'h0, 1'b1, rpt, 1'b1));
   endtask

   task automatic expect_expiry(input int n, input string req);
      wait_neg(n - 1);
      check({req, " irq before interval"}, 32'(irq), 32'd0);
      wait_neg(1);
      check({req, " irq at interval"}, 32'(irq), 32'd1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin : watchdog
      #1000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      finish_run();
   end

   initial begin : stim
      logic [31:0] d;
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(1);

      // R1: reset state
      check("R1 irq", 32'(irq), 32'd0);
      rd_reg(A_LOW, d); check("R1 low", d, 32'd0);
      rd_reg(A_CTL, d); check("R1 ctl", d, 32'd0);
      rd_reg(A_IS, d);  check("R1 ien", d, 32'd0);
      rd_reg(A_PD, d);  check("R1 pend", d, 32'd0);

      // R2: read-back and field layout, load strobe reads 0
      wr_reg(A_LOW, 32'hA5A5_1234);
      rd_reg(A_LOW, d); check("R2 low readback", d, 32'hA5A5_1234);
      wr_reg(A_CTL, ctl(24'hABCDEF, 1'b0, 1'b1, 1'b0));
      rd_reg(A_CTL, d); check("R2 ctl fields", d, ctl(24'hABCDEF, 1'b0, 1'b1, 1'b0));
      wr_reg(A_CTL, ctl(24'h000012, 1'b0, 1'b0, 1'b1));
      rd_reg(A_CTL, d); check("R2 load reads 0", d, ctl(24'h000012, 1'b0, 1'b0, 1'b0));
      rd_reg(A_IC, d);  check("R8 clr reg reads 0", d, 32'd0);
      wr_reg(A_CTL, 32'd0);

      // R8: enable set
      wr_reg(A_IS, 32'd1);
      rd_reg(A_IS, d); check("R8 ien set", d, 32'd1);

      // R3 + R4: one-shot
      arm(5, 1'b0);
      expect_expiry(5, "R3");
      rd_reg(A_CTL, d); check("R4 run cleared", d, 32'd0);
      rd_reg(A_PD, d);  check("R9 pend reads 1", d, 32'd1);
      wr_reg(A_PD, 32'd0);
      rd_reg(A_PD, d);  check("R10 write 0 ignored", d, 32'd1);
      wr_reg(A_PD, 32'd1);
      check("R10 clear drops irq", 32'(irq), 32'd0);
      wait_neg(20);
      check("R4 no re-expiry", 32'(irq), 32'd0);

      // R9: masking keeps the pending event
      arm(3, 1'b0);
      wait_neg(5);
      check("R9 irq pending+enabled", 32'(irq), 32'd1);
      wr_reg(A_IC, 32'd1);
      check("R9 masked irq", 32'(irq), 32'd0);
      rd_reg(A_PD, d); check("R9 pend kept", d, 32'd1);
      rd_reg(A_IS, d); check("R8 ien cleared", d, 32'd0);
      wr_reg(A_IS, 32'd1);
      check("R9 unmasked irq", 32'(irq), 32'd1);
      wr_reg(A_PD, 32'd1);

      // R5: repeat, period 4
      arm(4, 1'b1);
      expect_expiry(4, "R5");
      wr_reg(A_PD, 32'd1);
      wait_neg(2);
      check("R5 cleared before reload expiry", 32'(irq), 32'd0);
      wait_neg(1);
      check("R5 second expiry", 32'(irq), 32'd1);
      rd_reg(A_CTL, d); check("R5 still running", d, ctl(24'h0, 1'b1, 1'b1, 1'b0));

      // R10: clear on the same edge as an expiry (edge 12)
      wait_neg(3);
      wr_reg(A_PD, 32'd1);
      check("R10 expiry wins", 32'(irq), 32'd1);

      // R7: stop with zero
      wr_reg(A_CTL, 32'd0);
      wr_reg(A_PD, 32'd1);
      wait_neg(20);
      check("R7 stopped irq", 32'(irq), 32'd0);
      rd_reg(A_CTL, d); check("R7 ctl zero", d, 32'd0);

      // R6: pause and resume keep the count
      arm(20, 1'b0);
      wait_neg(5);
      wr_reg(A_CTL, ctl(24'h0, 1'b0, 1'b0, 1'b0));
      wait_neg(10);
      check("R6 paused irq", 32'(irq), 32'd0);
      wr_reg(A_CTL, ctl(24'h0, 1'b1, 1'b0, 1'b0));
      wait_neg(14);
      check("R6 resumed before end", 32'(irq), 32'd0);
      wait_neg(1);
      check("R6 resumed expiry", 32'(irq), 32'd1);
      wr_reg(A_PD, 32'd1);

      // R11: upper field participates
      wr_reg(A_LOW, 32'd3);
      wr_reg(A_CTL, ctl(24'h000001, 1'b1, 1'b0, 1'b1));
      wait_neg(300);
      check("R11 no early expiry", 32'(irq), 32'd0);
      rd_reg(A_CTL, d); check("R11 running", d, ctl(24'h000001, 1'b1, 1'b0, 1'b0));
      wr_reg(A_CTL, 32'd0);

      // Random intervals and modes
      void'($urandom(32'd77));
      for (int t = 0; t < 10; t++) begin
         int n;
         logic r;
         n = $urandom_range(2, 24);
         r = 1'($urandom_range(0, 1));
         wr_reg(A_PD, 32'd1);
         arm(n, r);
         expect_expiry(n, "R3");
         if (r) begin
            wr_reg(A_PD, 32'd1);
            wait_neg(n - 2);
            check("R5 random reload gap", 32'(irq), 32'd0);
            wait_neg(1);
            check("R5 random reload expiry", 32'(irq), 32'd1);
            wr_reg(A_CTL, 32'd0);
         end else begin
            rd_reg(A_CTL, d);
            check("R4 random one-shot halt", d, 32'd0);
         end
         wr_reg(A_PD, 32'd1);
      end

      finish_run();
   end

endmodule